// File: doc/BRIEF.md
# Memory and IO Slot Address Decoder

This block turns a 16-bit CPU bus address into one chip select for an external static RAM and eight chip selects for IO slots. RAM occupies the low part of the map, up to $BFFF. A 4 KB IO window above it, from $C000 to $CFFF, is cut into eight slots of 512 bytes each. Some ranges inside the RAM region belong to resources on the processor itself: the internal RAM page, the on-chip register block and, in boot mode, the boot ROM. Over these ranges the external RAM is kept off the bus. The top of the map, $D000 to $FFFF, selects nothing.

Selects are driven only while the bus qualifier reports a valid cycle. A flash-programming input, when high, forces every select inactive. The RAM's seventeenth address line comes from a strap input and is passed through. All outputs are registered, so they follow the inputs by one clock, and all selects are active low.

Top module: `addr_slot_decoder`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, ram_cs_n is 1, every bit of io_cs_n is 1 and ram_a16 is 0.
- R2: With bus_valid=1 and flash_prog=0, an address in $0000..$BFFF that no on-chip resource claims drives ram_cs_n to 0.
- R3: Addresses $0000..$00FF (internal RAM) leave ram_cs_n at 1.
- R4: Addresses $1000..$103F (register block) leave ram_cs_n at 1; $1040 selects RAM.
- R5: With boot_mode=1, addresses $BF00..$BFFF leave ram_cs_n at 1; with boot_mode=0 they select RAM.
- R6: An address in $C000..$CFFF drives io_cs_n bit k to 0, where k = (addr - $C000) / 512; slot 0 starts at $C000, slot 1 at $C200, slot 7 at $CE00.
- R7: Addresses $D000..$FFFF drive no select.
- R8: flash_prog=1 drives every select to 1 regardless of the address.
- R9: bus_valid=0 drives every select to 1.
- R10: At most one of the nine select outputs is 0 in any cycle.
- R11: ram_a16 equals the value of bank_strap one clock earlier.
- R12: Every output reflects the inputs sampled at the previous rising clock edge and does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | CPU address |
| bus_valid | input | 1 | High during a valid bus cycle |
| boot_mode | input | 1 | High when the boot ROM is mapped |
| flash_prog | input | 1 | High during flash programming; blocks all selects |
| bank_strap | input | 1 | Strap for the RAM's upper address line |
| ram_cs_n | output | 1 | External RAM select, active low |
| io_cs_n | output | 8 | IO slot selects, active low, bit k for slot k |
| ram_a16 | output | 1 | Registered upper RAM address line |

## Verification
The bench builds the decoder with its default parameters: a 16-bit address, eight slots of 512 bytes, the RAM top at $BFFF and the on-chip ranges as listed. These values put every range edge within reach of single vectors: both ends of the internal page, of the register block, of the boot window with the mode on and off, of each IO slot and of the empty top region. A sweep over all eight slot bases and the slot last bytes confirms the slot numbering.

// File: rtl/addr_slot_decoder.sv
module addr_slot_decoder #(
  parameter int ADDR_W = 16,
  parameter int N_SLOTS = 8,
  parameter int SLOT_BITS = 9,
  parameter logic [ADDR_W-1:0] RAM_TOP = 16'hBFFF,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h00FF,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h1000,
  parameter int REG_SIZE = 64,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hBF00,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hC000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               bus_valid,
  input  logic               boot_mode,
  input  logic               flash_prog,
  input  logic               bank_strap,
  output logic               ram_cs_n,
  output logic [N_SLOTS-1:0] io_cs_n,
  output logic               ram_a16
);
  localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam logic [ADDR_W-1:0] REG_END = REG_BASE + ADDR_W'(REG_SIZE - 1);
  localparam logic [ADDR_W-1:0] IO_TOP = IO_BASE + ADDR_W'(N_SLOTS * (1 << SLOT_BITS) - 1);

  logic go, in_int, in_reg, in_boot, in_ram, in_io;
  logic [SLOT_W-1:0] slot;
  logic ram_sel;
  logic [N_SLOTS-1:0] io_sel;

  assign go      = bus_valid & ~flash_prog;
  assign in_int  = addr <= INT_TOP;
  assign in_reg  = (addr >= REG_BASE) && (addr <= REG_END);
  assign in_boot = boot_mode && (addr >= BOOT_BASE) && (addr <= RAM_TOP);
  assign in_ram  = (addr <= RAM_TOP) && !in_int && !in_reg && !in_boot;
  assign in_io   = (addr >= IO_BASE) && (addr <= IO_TOP);
  assign slot    = SLOT_W'((addr - IO_BASE) >> SLOT_BITS);
  assign ram_sel = go & in_ram;

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    assign io_sel[k] = go & in_io & (slot == SLOT_W'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_cs_n <= 1'b1;
      io_cs_n  <= '1;
      ram_a16  <= 1'b0;
    end else begin
      ram_cs_n <= ~ram_sel;
      io_cs_n  <= ~io_sel;
      ram_a16  <= bank_strap;
    end
  end
endmodule

// File: rtl/addr_slot_decoder_chk.sv
module addr_slot_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        bus_valid,
  input logic        boot_mode,
  input logic        flash_prog,
  input logic        bank_strap,
  input logic        ram_cs_n,
  input logic [7:0]  io_cs_n,
  input logic        ram_a16
);
  // R8
  flash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_prog |=> (ram_cs_n && (&io_cs_n)));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (ram_cs_n && (&io_cs_n)));
  // R10
  one_hot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ram_cs_n, ~io_cs_n}) <= 1);
  // R7
  top_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 16'hD000) |=> (ram_cs_n && (&io_cs_n)));
  // R3
  int_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr <= 16'h00FF) |=> ram_cs_n);
  // R6
  slot_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !flash_prog && addr[15:12] == 4'hC) |=> !io_cs_n[$past(addr[11:9])]);
  // R11
  strap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ram_a16 == $past(bank_strap)));
endmodule

bind addr_slot_decoder addr_slot_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .bus_valid(bus_valid),
  .boot_mode(boot_mode), .flash_prog(flash_prog), .bank_strap(bank_strap),
  .ram_cs_n(ram_cs_n), .io_cs_n(io_cs_n), .ram_a16(ram_a16)
);

// File: tb/addr_slot_decoder_tb_top.sv
`timescale 1ns/1ps
module addr_slot_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic bus_valid = 1'b0, boot_mode = 1'b0, flash_prog = 1'b0, bank_strap = 1'b0;
  logic ram_cs_n, ram_a16;
  logic [7:0] io_cs_n;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  addr_slot_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .bus_valid(bus_valid),
    .boot_mode(boot_mode), .flash_prog(flash_prog), .bank_strap(bank_strap),
    .ram_cs_n(ram_cs_n), .io_cs_n(io_cs_n), .ram_a16(ram_a16)
  );

  // {req[3:0], addr[15:0], valid, boot, flash, exp_ram_n, exp_io_n[7:0]}
  localparam int NV = 22;
  localparam logic [31:0] VEC [NV] = '{
    {4'd3, 16'h0000, 3'b100, 1'b1, 8'hFF},  // R3
    {4'd3, 16'h00FF, 3'b100, 1'b1, 8'hFF},  // R3
    {4'd2, 16'h0100, 3'b100, 1'b0, 8'hFF},  // R2
    {4'd2, 16'h0FFF, 3'b100, 1'b0, 8'hFF},  // R2
    {4'd4, 16'h1000, 3'b100, 1'b1, 8'hFF},  // R4
    {4'd4, 16'h103F, 3'b100, 1'b1, 8'hFF},  // R4
    {4'd4, 16'h1040, 3'b100, 1'b0, 8'hFF},  // R4
    {4'd2, 16'h2000, 3'b100, 1'b0, 8'hFF},  // R2
    {4'd5, 16'hBEFF, 3'b110, 1'b0, 8'hFF},  // R5
    {4'd5, 16'hBF00, 3'b110, 1'b1, 8'hFF},  // R5
    {4'd5, 16'hBFFF, 3'b100, 1'b0, 8'hFF},  // R5
    {4'd5, 16'hBFFF, 3'b110, 1'b1, 8'hFF},  // R5
    {4'd6, 16'hC000, 3'b100, 1'b1, 8'hFE},  // R6
    {4'd6, 16'hC1FF, 3'b100, 1'b1, 8'hFE},  // R6
    {4'd6, 16'hC200, 3'b100, 1'b1, 8'hFD},  // R6
    {4'd6, 16'hCE00, 3'b100, 1'b1, 8'h7F},  // R6
    {4'd6, 16'hCFFF, 3'b100, 1'b1, 8'h7F},  // R6
    {4'd7, 16'hD000, 3'b100, 1'b1, 8'hFF},  // R7
    {4'd7, 16'hFFFF, 3'b110, 1'b1, 8'hFF},  // R7
    {4'd9, 16'h2000, 3'b000, 1'b1, 8'hFF},  // R9
    {4'd8, 16'hC400, 3'b101, 1'b1, 8'hFF},  // R8
    {4'd8, 16'h2000, 3'b101, 1'b1, 8'hFF}   // R8
  };

  task automatic check(input int req, input logic [9:0] act, input logic [9:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d addr=%h actual=%b expected=%b", req, addr, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic v, input logic b, input logic f);
    @(negedge clk);
    addr = a; bus_valid = v; boot_mode = b; flash_prog = f;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bank_strap = 1'b1;
    #9;
    // R1: reset state
    check(1, {ram_cs_n, io_cs_n, ram_a16}, {1'b1, 8'hFF, 1'b0});
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][27:12], VEC[i][11], VEC[i][10], VEC[i][9]);
      check(int'(VEC[i][31:28]), {ram_cs_n, io_cs_n, 1'b0}, {VEC[i][8:0], 1'b0});
      // R10
      check(10, {9'd0, ($countones({~ram_cs_n, ~io_cs_n}) <= 1)}, 10'd1);
    end
    // R6: every slot base and last byte
    for (int k = 0; k < 8; k++) begin
      apply(16'hC000 + 16'(k * 512), 1'b1, 1'b0, 1'b0);
      check(6, {ram_cs_n, io_cs_n, 1'b0}, {1'b1, ~(8'd1 << k), 1'b0});
      apply(16'hC1FF + 16'(k * 512), 1'b1, 1'b1, 1'b0);
      check(6, {ram_cs_n, io_cs_n, 1'b0}, {1'b1, ~(8'd1 << k), 1'b0});
    end
    // R11: strap follows one clock later
    @(negedge clk); bank_strap = 1'b0;
    #1 check(11, {9'd0, ram_a16}, 10'd1);
    @(negedge clk);
    check(11, {9'd0, ram_a16}, 10'd0);
    @(negedge clk); bank_strap = 1'b1;
    @(negedge clk);
    check(11, {9'd0, ram_a16}, 10'd1);
    // R12: outputs hold until the next rising edge
    apply(16'h3000, 1'b1, 1'b0, 1'b0);
    addr = 16'hC200;
    #1 check(12, {ram_cs_n, io_cs_n, 1'b0}, {1'b0, 8'hFF, 1'b0});
    @(negedge clk);
    check(12, {ram_cs_n, io_cs_n, 1'b0}, {1'b1, 8'hFD, 1'b0});
    // R1: reset mid-run clears selects
    rst_n = 1'b0;
    #1 check(1, {ram_cs_n, io_cs_n, ram_a16}, {1'b1, 8'hFF, 1'b0});
    @(negedge clk); rst_n = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule